// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor core that completes one instruction on every clock edge. It supports six operations: register add, register subtract, OR with an immediate, word load, word store and branch on equal. The core contains a program counter, a 32-entry register file, an immediate extender, a three-function ALU, a small instruction store and a small data store, and a combinational decoder.

The decoder works in two levels. The first level turns the opcode and function fields into one flag per instruction, with at most one flag set. The second level forms each of eight datapath control signals as an OR of the flags that need that signal high. Any control signal that does not matter for an instruction is driven low.

Both memories are filled through a load port while reset is held high. Execution starts from address 0 once reset is released. A registered trace of the program counter and of every register-file write gives an outside observer the full architectural effect of each instruction.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC becomes 0, all 32 registers become 0 and `dbg_wr_en` becomes 0. The load port may write both memories during reset.
- R2: Opcode 0x00 (bits 31:26) with function 0x20 (bits 5:0) writes rs+rt into register rd. The fields are rs in bits 25:21, rt in bits 20:16 and rd in bits 15:11.
- R3: Opcode 0x00 with function 0x22 writes rs−rt (modulo 2^32) into register rd.
- R4: Opcode 0x0D writes rs OR the zero-extended imm16 (bits 15:0) into register rt.
- R5: Opcode 0x23 writes into register rt the data word at byte address rs + sign-extended imm16. The word index is address bits [DMEM_AW+1:2].
- R6: Opcode 0x2B stores register rt at the same address form as R5 and writes no register.
- R7: Opcode 0x04 sets the next PC to PC+4+(sign-extended imm16 << 2) when rs equals rt, and to PC+4 otherwise. It writes no register.
- R8: Register 0 always reads as 0. A write aimed at it changes nothing and is not reported on `dbg_wr_en`.
- R9: Any other opcode, or opcode 0x00 with any other function code, changes no register and no memory and advances the PC by 4.
- R10: `dbg_pc` is the address of the instruction now executing. After each edge, `dbg_wr_en`/`dbg_wr_idx`/`dbg_wr_data` describe the register write made at that edge.
- R11: The decoder sets at most one instruction flag. Only the add, subtract, OR-immediate and load instructions write a register, and only the store writes the data memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr | input | LD_AW | Word index for the load-port write |
| ld_data | input | XLEN | Word written through the load port |
| dbg_pc | output | XLEN | Address of the instruction being executed |
| dbg_wr_en | output | 1 | A register write took place at the last edge |
| dbg_wr_idx | output | RAW | Register index of that write |
| dbg_wr_data | output | XLEN | Value written |

## Verification
A directed program runs first. It contrasts zero extension against sign extension by using an all-ones immediate for both the OR and the load/store offset. It places a not-taken compare next to a taken compare so the two branch outcomes can be told apart. It also aims a write at register 0, and it runs an undecoded opcode and an undecoded function code.

A second program re-dumps every register after a fresh reset, which shows that reset cleared state left dirty by the first program. Seeded random programs then mix all eight instruction kinds with dense register reuse and short forward and backward branches. These runs expose forwarding mistakes between the register file, the memory and the PC, since an error in any one of them shows up on the write and PC trace.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_LOAD = 6'h23;
  localparam logic [5:0] OPC_STOR = 6'h2B;
  localparam logic [5:0] OPC_BREQ = 6'h04;
  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] FN_SUB   = 6'h22;

  // ADD is code 0 so that an unused ALU selection defaults low
  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  // first decode level: one flag per instruction
  typedef struct packed {
    logic op_add;
    logic op_sub;
    logic op_ori;
    logic op_load;
    logic op_store;
    logic op_beq;
  } inst_flags_t;

  // second decode level: datapath controls
  typedef struct packed {
    logic    dst_rd;     // 1: write index from rd, 0: from rt
    logic    b_imm;      // 1: ALU second operand is the extended immediate
    logic    wb_mem;     // 1: write-back value from data memory
    logic    rf_we;      // register write
    logic    dm_we;      // data memory write
    logic    br_sel;     // branch candidate
    logic    imm_sign;   // 1: sign-extend, 0: zero-extend
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0]  opcode,
  input  logic [5:0]  fn,
  output inst_flags_t flags,
  output ctrl_t       ctrl
);

  logic is_reg;

  // AND plane
  always_comb begin
    is_reg         = (opcode == OPC_REG);
    flags          = '0;
    flags.op_add   = is_reg && (fn == FN_ADD);
    flags.op_sub   = is_reg && (fn == FN_SUB);
    flags.op_ori   = (opcode == OPC_ORI);
    flags.op_load  = (opcode == OPC_LOAD);
    flags.op_store = (opcode == OPC_STOR);
    flags.op_beq   = (opcode == OPC_BREQ);
  end

  // OR plane, every unlisted case stays 0
  always_comb begin
    ctrl          = '0;
    ctrl.dst_rd   = flags.op_add | flags.op_sub;
    ctrl.b_imm    = flags.op_ori | flags.op_load | flags.op_store;
    ctrl.wb_mem   = flags.op_load;
    ctrl.rf_we    = flags.op_add | flags.op_sub | flags.op_ori | flags.op_load;
    ctrl.dm_we    = flags.op_store;
    ctrl.br_sel   = flags.op_beq;
    ctrl.imm_sign = flags.op_load | flags.op_store;
    ctrl.alu_op   = alu_op_e'({flags.op_ori, flags.op_sub | flags.op_beq});
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter  int NREG = 32,
  parameter  int W    = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] rf [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (we && (waddr != '0)) begin
      rf[waddr] <= wdata;
    end
  end

  assign rdata_a = (raddr_a == '0) ? '0 : rf[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : rf[raddr_b];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_wordram.sv
module sc_wordram #(
  parameter  int AW    = 6,
  parameter  int W     = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // asynchronous read: the single-cycle path needs data in the same cycle
  assign rdata = mem[raddr];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter  int XLEN    = 32,
  parameter  int NREG    = 32,
  parameter  int IMEM_AW = 6,
  parameter  int DMEM_AW = 6,
  localparam int RAW     = $clog2(NREG),
  localparam int LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic             ld_dmem,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]  ld_data,
  output logic [XLEN-1:0]  dbg_pc,
  output logic             dbg_wr_en,
  output logic [RAW-1:0]   dbg_wr_idx,
  output logic [XLEN-1:0]  dbg_wr_data
);

  localparam int IMM_W = 16;

  logic [XLEN-1:0] pc_q, pc_seq, pc_br, pc_next;
  logic [XLEN-1:0] instr;
  logic [5:0]      f_op, f_fn;
  logic [4:0]      f_rs, f_rt, f_rd;
  logic [IMM_W-1:0] f_imm;

  inst_flags_t dec_flags;
  ctrl_t       dec_ctrl;

  logic [XLEN-1:0] bus_a, bus_b, imm_ext, alu_b, alu_y, dm_rdata, wb_data;
  logic            alu_zero;
  logic [RAW-1:0]  wr_idx;
  logic            rf_we;
  logic            br_taken;

  logic                im_we;
  logic                dm_we;
  logic [DMEM_AW-1:0]  dm_waddr;
  logic [XLEN-1:0]     dm_wdata;

  // ---------------- fetch ----------------
  assign im_we = ld_en && !ld_dmem;

  sc_wordram #(.AW(IMEM_AW), .W(XLEN)) u_imem (
    .clk   (clk),
    .we    (im_we),
    .waddr (ld_addr[IMEM_AW-1:0]),
    .wdata (ld_data),
    .raddr (pc_q[IMEM_AW+1:2]),
    .rdata (instr)
  );

  // ---------------- decode ----------------
  assign f_op  = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_fn  = instr[5:0];
  assign f_imm = instr[15:0];

  sc_ctrl u_ctrl (
    .opcode (f_op),
    .fn     (f_fn),
    .flags  (dec_flags),
    .ctrl   (dec_ctrl)
  );

  assign wr_idx = dec_ctrl.dst_rd ? RAW'(f_rd) : RAW'(f_rt);
  assign rf_we  = dec_ctrl.rf_we && !rst;

  sc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .waddr   (wr_idx),
    .wdata   (wb_data),
    .raddr_a (RAW'(f_rs)),
    .raddr_b (RAW'(f_rt)),
    .rdata_a (bus_a),
    .rdata_b (bus_b)
  );

  // ---------------- execute ----------------
  generate
    if (XLEN > IMM_W) begin : g_ext
      assign imm_ext = dec_ctrl.imm_sign ? {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm}
                                         : {{(XLEN-IMM_W){1'b0}}, f_imm};
    end else begin : g_noext
      assign imm_ext = f_imm[XLEN-1:0];
    end
  endgenerate

  assign alu_b = dec_ctrl.b_imm ? imm_ext : bus_b;

  sc_alu #(.W(XLEN)) u_alu (
    .a    (bus_a),
    .b    (alu_b),
    .op   (dec_ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // ---------------- memory ----------------
  assign dm_we    = (ld_en && ld_dmem) || (dec_ctrl.dm_we && !rst);
  assign dm_waddr = ld_en ? ld_addr[DMEM_AW-1:0] : alu_y[DMEM_AW+1:2];
  assign dm_wdata = ld_en ? ld_data : bus_b;

  sc_wordram #(.AW(DMEM_AW), .W(XLEN)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (alu_y[DMEM_AW+1:2]),
    .rdata (dm_rdata)
  );

  assign wb_data = dec_ctrl.wb_mem ? dm_rdata : alu_y;

  // ---------------- next PC ----------------
  // branch offset has its own sign extension; the shared extender is zero-extending for beq
  assign pc_seq   = pc_q + XLEN'(4);
  assign pc_br    = pc_seq + {{(XLEN-IMM_W-2){f_imm[IMM_W-1]}}, f_imm, 2'b00};
  assign br_taken = dec_ctrl.br_sel && alu_zero;
  assign pc_next  = br_taken ? pc_br : pc_seq;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  // ---------------- registered write trace ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_wr_en   <= 1'b0;
      dbg_wr_idx  <= '0;
      dbg_wr_data <= '0;
    end else begin
      dbg_wr_en   <= dec_ctrl.rf_we && (wr_idx != '0);
      dbg_wr_idx  <= wr_idx;
      dbg_wr_data <= wb_data;
    end
  end

  assign dbg_pc = pc_q;

  logic unused_bits;
  assign unused_bits = ^{instr[10:6], pc_q[1:0], pc_q[XLEN-1:IMEM_AW+2],
                         alu_y[1:0], alu_y[XLEN-1:DMEM_AW+2]};

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
#(
  parameter  int XLEN = 32,
  parameter  int NREG = 32,
  localparam int RAW  = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc,
  input inst_flags_t     flags,
  input ctrl_t           ctrl,
  input logic            wr_en,
  input logic [RAW-1:0]  wr_idx
);

  // R1: reset returns the PC to zero and silences the write trace
  p_pc_reset_r1: assert property (@(posedge clk) rst |=> (pc == '0) && !wr_en)
    else $error("p_pc_reset_r1");

  // R11: first decode level never raises two flags
  p_flags_onehot_r11: assert property (@(posedge clk) disable iff (rst) $onehot0(flags))
    else $error("p_flags_onehot_r11");

  // R6: a store never also writes a register
  p_store_no_rf_r6: assert property (@(posedge clk) disable iff (rst) ctrl.dm_we |-> !ctrl.rf_we)
    else $error("p_store_no_rf_r6");

  // R9: anything that is not a branch candidate advances the PC by four
  p_seq_pc_r9: assert property (@(posedge clk) disable iff (rst)
      !ctrl.br_sel |=> pc == $past(pc) + XLEN'(4))
    else $error("p_seq_pc_r9");

  // R8: a reported write never names register 0
  p_no_r0_trace_r8: assert property (@(posedge clk) disable iff (rst) wr_en |-> wr_idx != '0)
    else $error("p_no_r0_trace_r8");

  // R7: PC stays word aligned
  p_pc_align_r7: assert property (@(posedge clk) disable iff (rst) pc[1:0] == 2'b00)
    else $error("p_pc_align_r7");

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .pc     (pc_q),
  .flags  (dec_flags),
  .ctrl   (dec_ctrl),
  .wr_en  (dbg_wr_en),
  .wr_idx (dbg_wr_idx)
);

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN    = 32;
  localparam int NREG    = 32;
  localparam int IMEM_AW = 6;
  localparam int DMEM_AW = 6;
  localparam int IDEPTH  = 1 << IMEM_AW;
  localparam int DDEPTH  = 1 << DMEM_AW;
  localparam int LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0;
  logic ld_dmem = 1'b0;
  logic [LD_AW-1:0] ld_addr = '0;
  logic [XLEN-1:0]  ld_data = '0;
  logic [XLEN-1:0]  dbg_pc;
  logic             dbg_wr_en;
  logic [4:0]       dbg_wr_idx;
  logic [XLEN-1:0]  dbg_wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core #(.XLEN(XLEN), .NREG(NREG), .IMEM_AW(IMEM_AW), .DMEM_AW(DMEM_AW)) dut_i (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem), .ld_addr(ld_addr),
    .ld_data(ld_data), .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en),
    .dbg_wr_idx(dbg_wr_idx), .dbg_wr_data(dbg_wr_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference model state
  logic [31:0] m_reg  [NREG];
  logic [31:0] m_imem [IDEPTH];
  logic [31:0] m_dmem [DDEPTH];
  logic [31:0] m_pc;
  logic        e_en;
  logic [4:0]  e_idx;
  logic [31:0] e_data;
  string       t_pc, t_en, t_data, force_tag;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // executes the instruction at m_pc following R2..R11
  task automatic model_step();
    logic [31:0] ins, a, b, sx, zx, npc, addr, val;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, idx;
    logic        wr;
    string       req;
    ins = m_imem[m_pc[IMEM_AW+1:2]];
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
    a  = m_reg[rs]; b = m_reg[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    zx = {16'h0, ins[15:0]};
    npc = m_pc + 32'd4;
    wr = 0; idx = 0; val = 0; req = "R9";
    if (op == 6'h00 && fn == 6'h20) begin wr = 1; idx = rd; val = a + b; req = "R2"; end
    else if (op == 6'h00 && fn == 6'h22) begin wr = 1; idx = rd; val = a - b; req = "R3"; end
    else if (op == 6'h0D) begin wr = 1; idx = rt; val = a | zx; req = "R4"; end
    else if (op == 6'h23) begin
      addr = a + sx; wr = 1; idx = rt; val = m_dmem[addr[DMEM_AW+1:2]]; req = "R5";
    end else if (op == 6'h2B) begin
      addr = a + sx; m_dmem[addr[DMEM_AW+1:2]] = b; req = "R6";
    end else if (op == 6'h04) begin
      req = "R7";
      if (a == b) npc = m_pc + 32'd4 + (sx << 2);
    end
    if (wr && idx != 0) m_reg[idx] = val;
    e_en = wr && (idx != 0);
    e_idx = idx; e_data = val;
    m_pc = npc;
    t_pc   = (req == "R7" || req == "R9") ? req : "R10";
    t_en   = wr ? ((idx == 0) ? "R8" : req) : ((req == "R6") ? "R6" : "R11");
    t_data = (force_tag != "") ? force_tag : req;
  endtask

  task automatic load_and_reset();
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < IDEPTH; i++) begin
      ld_en = 1; ld_dmem = 0; ld_addr = LD_AW'(i); ld_data = m_imem[i];
      @(negedge clk);
    end
    for (int i = 0; i < DDEPTH; i++) begin
      ld_en = 1; ld_dmem = 1; ld_addr = LD_AW'(i); ld_data = m_dmem[i];
      @(negedge clk);
    end
    ld_en = 0;
    @(negedge clk);
    chk("R1", "reset pc", dbg_pc, 32'h0);
    chk("R1", "reset wr_en", {31'h0, dbg_wr_en}, 32'h0);
    for (int i = 0; i < NREG; i++) m_reg[i] = '0;
    m_pc = '0;
    rst = 1'b0;
  endtask

  task automatic run(int ncyc);
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      model_step();
      chk(t_pc, "pc", dbg_pc, m_pc);
      chk(t_en, "wr_en", {31'h0, dbg_wr_en}, {31'h0, e_en});
      if (e_en) begin
        chk(t_data, "wr_idx", {27'h0, dbg_wr_idx}, {27'h0, e_idx});
        chk(t_data, "wr_data", dbg_wr_data, e_data);
      end
    end
  endtask

  function automatic logic [31:0] rand_instr();
    int k, rs, rt, rd;
    logic [15:0] imm;
    k  = $urandom_range(0, 7);
    rs = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 31) : $urandom_range(0, 7);
    rt = $urandom_range(0, 7);
    rd = $urandom_range(0, 7);
    imm = 16'($urandom);
    case (k)
      0: return enc_r(rs, rt, rd, 6'h20);
      1: return enc_r(rs, rt, rd, 6'h22);
      2: return enc_i(6'h0D, rs, rt, imm);
      3: return enc_i(6'h23, rs, rt, imm);
      4: return enc_i(6'h2B, rs, rt, imm);
      5: return enc_i(6'h04, rs, rt, 16'($signed($urandom_range(0, 8)) - 4));
      6: return enc_i(6'h3F, rs, rt, imm);
      default: return enc_r(rs, rt, rd, 6'h25);
    endcase
  endfunction

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    force_tag = "";
    // directed program
    for (int i = 0; i < IDEPTH; i++) m_imem[i] = '0;
    for (int i = 0; i < DDEPTH; i++) m_dmem[i] = 32'h1000_0000 + 32'(i);
    m_imem[0]  = enc_i(6'h0D, 0, 1, 16'h0005);      // R4
    m_imem[1]  = enc_i(6'h0D, 0, 2, 16'hFFFF);      // R4 zero extension
    m_imem[2]  = enc_r(1, 2, 3, 6'h20);             // R2
    m_imem[3]  = enc_r(1, 2, 4, 6'h22);             // R3 wraps
    m_imem[4]  = enc_i(6'h2B, 1, 3, 16'hFFFF);      // R6 address 4
    m_imem[5]  = enc_i(6'h23, 1, 5, 16'hFFFF);      // R5 reads back
    m_imem[6]  = enc_i(6'h04, 1, 2, 16'h0005);      // R7 not taken
    m_imem[7]  = enc_i(6'h04, 1, 1, 16'h0001);      // R7 taken
    m_imem[8]  = enc_i(6'h0D, 0, 6, 16'h0BAD);      // skipped
    m_imem[9]  = enc_i(6'h0D, 0, 0, 16'h1234);      // R8 write to r0
    m_imem[10] = enc_r(0, 0, 7, 6'h20);             // R8 r0 reads zero
    m_imem[11] = enc_i(6'h3F, 1, 2, 16'h0000);      // R9 undecoded opcode
    m_imem[12] = enc_r(1, 2, 8, 6'h25);             // R9 undecoded function
    m_imem[13] = enc_i(6'h23, 0, 9, 16'h0004);      // R5 word 1 after store
    m_imem[14] = enc_i(6'h04, 0, 0, 16'hFFF0);      // R7 backward branch
    load_and_reset();
    run(20);

    // R1: registers cleared by reset, dumped via rK = rK + r0
    for (int i = 0; i < IDEPTH; i++) m_imem[i] = '0;
    for (int k = 1; k < NREG; k++) m_imem[k-1] = enc_r(k, 0, k, 6'h20);
    force_tag = "R1";
    load_and_reset();
    run(NREG - 1);
    force_tag = "";

    // seeded random programs
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < IDEPTH; i++) m_imem[i] = rand_instr();
      for (int i = 0; i < DDEPTH; i++) m_dmem[i] = $urandom;
      load_and_reset();
      run(150);
    end

    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

endmodule